// File: doc/BRIEF.md
# Load/Store Alignment and Rotation Unit

This unit sits between the load/store stage of a CPU pipeline and a 32-bit memory port. Each request (access size, direction, address) is judged against two configuration bits: an alignment-check enable and an unaligned-support enable. One cycle later the unit produces exactly one outcome. It either issues a memory access with a conditioned address, or it raises an alignment-fault strobe with a status code, in which case nothing goes to memory.

The two configuration bits select one of four behaviours. With both bits clear the unit runs in legacy mode. In that mode it clears the low address bits to the natural boundary of the access, and it rotates the data returned for a single-word load right by the byte offset of that load. With checking enabled, any naturally misaligned access faults. With only unaligned support enabled, halfword and word accesses go to memory with their low address bits intact, while doubleword and multiple accesses must still be word aligned.

Read data returned on the memory side comes out one cycle later. It is rotated only when the most recently issued load was a legacy single-word load; otherwise it comes out unchanged.

Top module: `lsu_align_unit`

## Requirements
- R1: While reset is high and after its release, `mem_valid`, `fault_valid` and `ld_valid` are 0 until a request or read data arrives.
- R2: A cycle with `req_valid`=1 produces exactly one of `mem_valid` or `fault_valid` in the next cycle. A cycle without `req_valid` produces neither.
- R3: With `cfg_align_chk`=1, the following accesses fault: a halfword with address bit 0 set; a word or multiple access with address bits [1:0] not 00; a doubleword with address bits [2:0] not 000. Byte accesses never fault.
- R4: A fault drives `fault_status`=5'b00001 and issues no memory access. `fault_status` is 0 in every cycle without a fault.
- R5: In legacy mode (both configuration bits 0) no access faults. The address sent to memory has these low bits cleared: none for byte, bit 0 for halfword, bits [1:0] for word and multiple, bits [2:0] for doubleword.
- R6: With `cfg_unaligned_en`=1 and `cfg_align_chk`=0, byte, halfword and word addresses pass to memory unchanged. Doubleword and multiple accesses fault when address bits [1:0] are not 00, and otherwise pass unchanged.
- R7: `mem_size` and `mem_is_load` copy the request. Sizes are encoded as 000 byte, 001 halfword, 010 word, 011 doubleword and 100 multiple. Codes 101 to 111 are handled as byte.
- R8: When the last issued load was a legacy-mode word load, `ld_data` equals `rd_data` rotated right by 8 times that load's address bits [1:0]. `ld_valid` follows `rd_valid` by one cycle.
- R9: When the last issued load was of any other kind, `ld_data` is the raw `rd_data`. This covers byte, halfword, doubleword and multiple loads, and any load issued with a configuration bit set. Stores never change the rotation that later read data receives.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present this cycle |
| req_size | input | 3 | Access size code |
| req_is_load | input | 1 | 1 for load, 0 for store |
| req_addr | input | 32 | Byte address of the access |
| cfg_align_chk | input | 1 | Alignment-check enable |
| cfg_unaligned_en | input | 1 | Unaligned-support enable |
| rd_valid | input | 1 | Memory read data present |
| rd_data | input | 32 | Memory read word |
| mem_valid | output | 1 | Memory access issued |
| mem_addr | output | 32 | Conditioned memory address |
| mem_size | output | 3 | Size of the issued access |
| mem_is_load | output | 1 | Direction of the issued access |
| fault_valid | output | 1 | Alignment fault strobe |
| fault_status | output | 5 | Fault status code |
| ld_valid | output | 1 | Load data valid |
| ld_data | output | 32 | Load data after optional rotation |

## Verification
The only state that outlives a cycle is the rotation record of the last issued load. If that record is wrong, the error stays hidden until the next read-data beat, and then shows up as a byte-permuted `ld_data` one cycle after that beat. Bad fault or address logic shows up on `fault_valid`, `mem_valid` or `mem_addr` in the cycle right after the request. The bench's reference model therefore compares every output on every clock. It keeps its own record of the last load and places loads, stores and read beats in the same and in neighbouring cycles.

// File: rtl/lsu_align_pkg.sv
package lsu_align_pkg;

    localparam int LSU_AW = 32;
    localparam int LSU_DW = 32;
    localparam int LSU_SZW = 3;
    localparam int LSU_STW = 5;

    typedef enum logic [LSU_SZW-1:0] {
        SZ_BYTE  = 3'b000,
        SZ_HALF  = 3'b001,
        SZ_WORD  = 3'b010,
        SZ_DWORD = 3'b011,
        SZ_MULTI = 3'b100
    } acc_size_e;

    localparam logic [LSU_STW-1:0] FLT_NONE  = 5'b00000;
    localparam logic [LSU_STW-1:0] FLT_ALIGN = 5'b00001;

endpackage

// File: rtl/lsu_align_check.sv
module lsu_align_check
    import lsu_align_pkg::*;
(
    input  logic [LSU_SZW-1:0] size,
    input  logic [2:0]         addr_lo,
    input  logic               chk_en,
    input  logic               unal_en,
    output logic               fault
);
    logic strict_mis;
    logic word_mis;

    always_comb begin
        word_mis = (addr_lo[1:0] != 2'b00);
        case (size)
            SZ_HALF:           strict_mis = addr_lo[0];
            SZ_WORD, SZ_MULTI: strict_mis = word_mis;
            SZ_DWORD:          strict_mis = (addr_lo != 3'b000);
            default:           strict_mis = 1'b0;
        endcase
        if (chk_en) begin
            fault = strict_mis;
        end else if (unal_en) begin
            fault = word_mis && ((size == SZ_DWORD) || (size == SZ_MULTI));
        end else begin
            fault = 1'b0;
        end
    end

endmodule

// File: rtl/lsu_addr_shape.sv
module lsu_addr_shape
    import lsu_align_pkg::*;
#(
    parameter int AW = LSU_AW
) (
    input  logic [AW-1:0]      addr_in,
    input  logic [LSU_SZW-1:0] size,
    input  logic               legacy,
    output logic [AW-1:0]      addr_out
);
    logic [2:0] clr;

    always_comb begin
        case (size)
            SZ_HALF:           clr = 3'b001;
            SZ_WORD, SZ_MULTI: clr = 3'b011;
            SZ_DWORD:          clr = 3'b111;
            default:           clr = 3'b000;
        endcase
        addr_out = addr_in;
        if (legacy) begin
            addr_out[2:0] = addr_in[2:0] & ~clr;
        end
    end

endmodule

// File: rtl/lsu_load_rotate.sv
module lsu_load_rotate #(
    parameter int DW = 32,
    localparam int NB = DW / 8,
    localparam int LW = (NB > 1) ? $clog2(NB) : 1
) (
    input  logic [DW-1:0] data_in,
    input  logic [LW-1:0] amt,
    output logic [DW-1:0] data_out
);
    logic [DW-1:0] cand [NB];

    for (genvar k = 0; k < NB; k++) begin : g_rot
        if (k == 0) begin : g_zero
            assign cand[k] = data_in;
        end else begin : g_shift
            assign cand[k] = {data_in[8*k-1:0], data_in[DW-1:8*k]};
        end
    end

    always_comb begin
        data_out = cand[0];
        for (int i = 1; i < NB; i++) begin
            if (amt == LW'(i)) data_out = cand[i];
        end
    end

endmodule

// File: rtl/lsu_align_unit.sv
module lsu_align_unit
    import lsu_align_pkg::*;
#(
    parameter int AW = LSU_AW,
    parameter int DW = LSU_DW,
    localparam int NB = DW / 8,
    localparam int LW = (NB > 1) ? $clog2(NB) : 1
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               req_valid,
    input  logic [LSU_SZW-1:0] req_size,
    input  logic               req_is_load,
    input  logic [AW-1:0]      req_addr,
    input  logic               cfg_align_chk,
    input  logic               cfg_unaligned_en,
    input  logic               rd_valid,
    input  logic [DW-1:0]      rd_data,
    output logic               mem_valid,
    output logic [AW-1:0]      mem_addr,
    output logic [LSU_SZW-1:0] mem_size,
    output logic               mem_is_load,
    output logic               fault_valid,
    output logic [LSU_STW-1:0] fault_status,
    output logic               ld_valid,
    output logic [DW-1:0]      ld_data
);
    typedef struct packed {
        logic               mem_valid;
        logic [AW-1:0]      mem_addr;
        logic [LSU_SZW-1:0] mem_size;
        logic               mem_is_load;
        logic               fault_valid;
        logic [LSU_STW-1:0] fault_status;
        logic               rot_en;
        logic [LW-1:0]      rot_amt;
        logic               ld_valid;
        logic [DW-1:0]      ld_data;
    } stage_t;

    stage_t st_d, st_q;

    logic          legacy_d;
    logic          fault_d;
    logic [AW-1:0] shaped_d;
    logic [DW-1:0] rotated_d;

    assign legacy_d = !cfg_align_chk && !cfg_unaligned_en;

    lsu_align_check u_check (
        .size    (req_size),
        .addr_lo (req_addr[2:0]),
        .chk_en  (cfg_align_chk),
        .unal_en (cfg_unaligned_en),
        .fault   (fault_d)
    );

    lsu_addr_shape #(.AW(AW)) u_shape (
        .addr_in  (req_addr),
        .size     (req_size),
        .legacy   (legacy_d),
        .addr_out (shaped_d)
    );

    lsu_load_rotate #(.DW(DW)) u_rot (
        .data_in  (rd_data),
        .amt      (st_q.rot_amt),
        .data_out (rotated_d)
    );

    always_comb begin
        st_d = st_q;
        st_d.mem_valid    = 1'b0;
        st_d.fault_valid  = 1'b0;
        st_d.fault_status = FLT_NONE;
        if (req_valid) begin
            if (fault_d) begin
                st_d.fault_valid  = 1'b1;
                st_d.fault_status = FLT_ALIGN;
            end else begin
                st_d.mem_valid   = 1'b1;
                st_d.mem_addr    = shaped_d;
                st_d.mem_size    = req_size;
                st_d.mem_is_load = req_is_load;
                if (req_is_load) begin
                    st_d.rot_en  = legacy_d && (req_size == SZ_WORD);
                    st_d.rot_amt = req_addr[LW-1:0];
                end
            end
        end
        st_d.ld_valid = rd_valid;
        if (rd_valid) begin
            st_d.ld_data = st_q.rot_en ? rotated_d : rd_data;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign mem_valid    = st_q.mem_valid;
    assign mem_addr     = st_q.mem_addr;
    assign mem_size     = st_q.mem_size;
    assign mem_is_load  = st_q.mem_is_load;
    assign fault_valid  = st_q.fault_valid;
    assign fault_status = st_q.fault_status;
    assign ld_valid     = st_q.ld_valid;
    assign ld_data      = st_q.ld_data;

    // R2
    one_outcome_chk: assert property (@(posedge clk) disable iff (rst)
        req_valid |=> (mem_valid != fault_valid));

    // R2
    no_spurious_chk: assert property (@(posedge clk) disable iff (rst)
        !req_valid |=> (!mem_valid && !fault_valid));

    // R3
    half_strict_chk: assert property (@(posedge clk) disable iff (rst)
        (req_valid && cfg_align_chk && req_size == SZ_HALF && req_addr[0]) |=> fault_valid);

    // R4
    fault_code_chk: assert property (@(posedge clk) disable iff (rst)
        fault_valid |-> (fault_status == FLT_ALIGN && !mem_valid));

    // R4
    quiet_code_chk: assert property (@(posedge clk) disable iff (rst)
        !fault_valid |-> (fault_status == FLT_NONE));

    // R5
    legacy_word_chk: assert property (@(posedge clk) disable iff (rst)
        (req_valid && !cfg_align_chk && !cfg_unaligned_en && req_size == SZ_WORD)
        |=> (mem_valid && mem_addr[1:0] == 2'b00));

    // R6
    unal_pass_chk: assert property (@(posedge clk) disable iff (rst)
        (req_valid && !cfg_align_chk && cfg_unaligned_en && req_size == SZ_HALF)
        |=> (mem_valid && mem_addr == $past(req_addr)));

    // R8
    ld_follow_chk: assert property (@(posedge clk) disable iff (rst)
        rd_valid |=> ld_valid);

endmodule

// File: tb/lsu_align_unit_test.sv
module lsu_align_unit_test;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req_valid = 1'b0;
    logic [2:0]  req_size = 3'd0;
    logic        req_is_load = 1'b0;
    logic [31:0] req_addr = 32'd0;
    logic        cfg_align_chk = 1'b0;
    logic        cfg_unaligned_en = 1'b0;
    logic        rd_valid = 1'b0;
    logic [31:0] rd_data = 32'd0;
    logic        mem_valid;
    logic [31:0] mem_addr;
    logic [2:0]  mem_size;
    logic        mem_is_load;
    logic        fault_valid;
    logic [4:0]  fault_status;
    logic        ld_valid;
    logic [31:0] ld_data;

    int checks = 0;
    int fails = 0;
    bit done = 1'b0;

    // reference record of the last issued load
    bit m_rot_en = 1'b0;
    int m_rot_amt = 0;

    always #4 clk = ~clk;

    lsu_align_unit uut (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_size(req_size),
        .req_is_load(req_is_load), .req_addr(req_addr),
        .cfg_align_chk(cfg_align_chk), .cfg_unaligned_en(cfg_unaligned_en),
        .rd_valid(rd_valid), .rd_data(rd_data), .mem_valid(mem_valid),
        .mem_addr(mem_addr), .mem_size(mem_size), .mem_is_load(mem_is_load),
        .fault_valid(fault_valid), .fault_status(fault_status),
        .ld_valid(ld_valid), .ld_data(ld_data)
    );

    task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    function automatic int grain(input int sz);
        case (sz)
            1: return 2;
            2: return 4;
            3: return 8;
            4: return 4;
            default: return 1;
        endcase
    endfunction

    function automatic int need(input int sz, input bit u, input bit a);
        if (a) return grain(sz);
        if (u && (sz == 3 || sz == 4)) return 4;
        return 1;
    endfunction

    // one clock: drive at falling edge, compare at the next falling edge
    task automatic step(input bit v, input int sz, input bit ld, input logic [31:0] ad,
                        input bit u, input bit a, input bit rv, input logic [31:0] rdd,
                        input string tag, input string ltag);
        bit e_fault;
        logic [31:0] e_addr;
        logic [31:0] e_ld;
        longint unsigned dbl;
        req_valid = v; req_size = 3'(sz); req_is_load = ld; req_addr = ad;
        cfg_unaligned_en = u; cfg_align_chk = a; rd_valid = rv; rd_data = rdd;
        e_fault = v && ((ad % need(sz, u, a)) != 0);
        e_addr = (!u && !a) ? (ad - (ad % grain(sz))) : ad;
        dbl = {rdd, rdd};
        e_ld = m_rot_en ? 32'(dbl >> (8 * m_rot_amt)) : rdd;
        if (v && !e_fault && ld) begin
            m_rot_en = !u && !a && sz == 2;
            m_rot_amt = ad % 4;
        end
        @(negedge clk);
        chk("R2", {tag, " mem_valid"}, 32'(mem_valid), 32'(v && !e_fault));
        chk(tag, "fault_valid", 32'(fault_valid), 32'(e_fault));
        chk("R4", {tag, " fault_status"}, 32'(fault_status), e_fault ? 32'd1 : 32'd0);
        if (v && !e_fault) begin
            chk(tag, "mem_addr", mem_addr, e_addr);
            chk("R7", "mem_size", 32'(mem_size), 32'(sz));
            chk("R7", "mem_is_load", 32'(mem_is_load), 32'(ld));
        end
        chk("R8", "ld_valid", 32'(ld_valid), 32'(rv));
        if (rv) chk(ltag, "ld_data", ld_data, e_ld);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        chk("R1", "mem_valid in reset", 32'(mem_valid), 0);
        chk("R1", "fault_valid in reset", 32'(fault_valid), 0);
        chk("R1", "ld_valid in reset", 32'(ld_valid), 0);
        rst = 1'b0;
        @(negedge clk);
        chk("R1", "mem_valid after reset", 32'(mem_valid), 0);
        chk("R1", "fault_valid after reset", 32'(fault_valid), 0);
        chk("R1", "ld_valid after reset", 32'(ld_valid), 0);

        // legacy masking, R5
        step(1, 0, 1, 32'h0000_1003, 0, 0, 0, 0, "R5", "R9");
        step(1, 1, 1, 32'h0000_1003, 0, 0, 0, 0, "R5", "R9");
        step(1, 2, 0, 32'h0000_1003, 0, 0, 0, 0, "R5", "R9");
        step(1, 3, 0, 32'h0000_100F, 0, 0, 0, 0, "R5", "R9");
        step(1, 4, 1, 32'h0000_1006, 0, 0, 0, 0, "R5", "R9");
        step(1, 7, 1, 32'h0000_1007, 0, 0, 0, 0, "R7", "R9");
        step(0, 0, 0, 0, 0, 0, 0, 0, "R2", "R9");

        // strict checking, R3
        for (int m = 0; m < 2; m++) begin
            for (int s = 0; s < 5; s++) begin
                for (int off = 0; off < 8; off++) begin
                    step(1, s, off[0], 32'h0000_2000 + 32'(off), m[0], 1, 0, 0, "R3", "R9");
                end
            end
        end

        // unaligned support without check, R6
        for (int s = 0; s < 5; s++) begin
            for (int off = 0; off < 8; off++) begin
                step(1, s, off[1], 32'h0000_3000 + 32'(off), 1, 0, 0, 0, "R6", "R9");
            end
        end

        // legacy word-load rotation at every offset, R8
        for (int off = 0; off < 4; off++) begin
            step(1, 2, 1, 32'h0000_4000 + 32'(off), 0, 0, 0, 0, "R5", "R8");
            step(0, 0, 0, 0, 0, 0, 1, 32'h4433_2211, "R2", "R8");
        end
        // store after rotating load leaves rotation alone
        step(1, 2, 0, 32'h0000_4001, 0, 0, 0, 0, "R5", "R9");
        step(0, 0, 0, 0, 0, 0, 1, 32'hA1B2_C3D4, "R2", "R9");
        // multiple load: raw data
        step(1, 4, 1, 32'h0000_4003, 0, 0, 0, 0, "R5", "R9");
        step(0, 0, 0, 0, 0, 0, 1, 32'hA1B2_C3D4, "R2", "R9");
        // unaligned-mode word load: raw data
        step(1, 2, 1, 32'h0000_4002, 1, 0, 0, 0, "R6", "R9");
        step(0, 0, 0, 0, 0, 0, 1, 32'h0102_0304, "R2", "R9");
        // read beat in the same cycle as a new rotating load
        step(1, 2, 1, 32'h0000_4001, 0, 0, 0, 0, "R5", "R8");
        step(1, 1, 1, 32'h0000_4003, 0, 0, 1, 32'hDEAD_BEEF, "R5", "R8");
        step(0, 0, 0, 0, 0, 0, 1, 32'hCAFE_F00D, "R2", "R9");

        // mixed traffic
        begin
            logic [31:0] lf = 32'h1234_5679;
            for (int i = 0; i < 400; i++) begin
                lf = {lf[30:0], lf[31] ^ lf[21] ^ lf[1] ^ lf[0]};
                step(lf[3], (lf[7:5] % 5 == 0) ? int'(lf[7:5]) : int'(lf[7:5]) % 5, lf[8], lf,
                     lf[9], lf[10] & lf[11], lf[12], lf ^ 32'h5A5A_0F0F,
                     lf[10] & lf[11] ? "R3" : (lf[9] ? "R6" : "R5"),
                     m_rot_en ? "R8" : "R9");
            end
        end

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual running expected done");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

endmodule